// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit core fetches from next. Each cycle it takes the address of the current instruction, the instruction word and the two register values read for it. It decodes the control-flow instructions and tests their condition. From these it produces the following fetch address, a flag that says whether control flow was redirected, and a request to write the return address into the link register.

Three instruction families are handled. Conditional branches compare two registers for equality, or compare one register against zero by its sign. Their target is relative to the following instruction. Absolute jumps keep the top four bits of the following address and take the rest from the 26-bit instruction field. A register jump takes its target straight from the first source operand. The jump-and-link form also returns the address two instructions past the current one, which leaves room for one delay slot. Every other instruction falls through to the next sequential address.

The results are registered, so the outputs show the decision for the inputs sampled at the previous rising clock edge. The register file, the fetch pipeline and delay-slot sequencing are left to the surrounding core.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `next_pc_o` equals the parameter RESET_PC (default 0), and `taken_o` and `link_we_o` are 0, whatever the inputs are.
- R2: The outputs change only at a rising clock edge. They reflect the inputs sampled at that edge and hold their values between edges.
- R3: Fields are opcode = instr[31:26], first register = instr[25:21], second register = instr[20:16], offset = instr[15:0]. Opcode 4 is taken when `rs_val_i == rt_val_i` and opcode 5 is taken when they differ. The taken target is pc+4 plus the sign-extended offset shifted left by 2, with 32-bit wrap-around.
- R4: Opcode 1 reads the second register field as a sub-opcode. Value 0 is taken when `rs_val_i` is negative. Value 1 is taken when `rs_val_i` is zero or positive. The target is formed as in R3.
- R5: Opcode 1 with any sub-opcode other than 0 or 1 is not taken.
- R6: Opcode 6 is taken when `rs_val_i` <= 0, and opcode 7 is taken when `rs_val_i` > 0. Both require the second register field to be 0; any other value there makes the instruction not taken. The target is formed as in R3.
- R7: Opcode 2 is always taken. Its target is (pc+4)[31:28], then instr[25:0], then two zero bits.
- R8: Opcode 0 with function code instr[5:0] = 0x08 is always taken, with `next_pc_o` equal to `rs_val_i`. Opcode 0 with any other function code is not taken.
- R9: Opcode 3 jumps to the target defined in R7. It also sets `link_we_o` = 1, `link_addr_o` = 31 and `link_data_o` = pc+8. No other instruction raises `link_we_o`.
- R10: For any instruction that is not taken, including all non-control opcodes, `next_pc_o` = pc+4 and `taken_o` = 0.
- R11: All conditions treat register values as two's-complement signed 32-bit numbers. 0x80000000 counts as negative and 0x7FFFFFFF counts as positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the register named by instr[25:21] |
| rt_val_i | input | 32 | Value of the register named by instr[20:16] |
| next_pc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Registered redirect flag |
| link_we_o | output | 1 | Registered link-register write request |
| link_addr_o | output | 5 | Link register index (31) |
| link_data_o | output | 32 | Registered return address |

## Verification
Each condition is driven on both sides of its decision. The register pairs are equal, unequal, zero, one above zero and the two extreme signed values, which separates signed from unsigned and strict from non-strict comparison. The branch offsets are positive and negative, which exposes a missing sign extension or a missing shift. A jump is placed where pc and pc+4 fall in different 256 MB regions, which shows which address supplies the upper bits. Invalid sub-opcodes, a nonzero second field on the zero-compare forms, and a non-jump function code under opcode 0 confirm that the fallthrough path is taken. A branch at the top of the address space checks wrap-around.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 32;
  localparam int OPW  = 6;
  localparam int REGW = 5;
  localparam int IMMW = 16;
  localparam int TGTW = 26;
  localparam int FNW  = 6;
  localparam int REGION_W = XLEN - TGTW - 2;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    K_NONE, K_BEQ, K_BNE, K_BLTZ, K_BGEZ, K_BLEZ, K_BGTZ, K_J, K_JAL, K_JR
  } kind_e;

  localparam logic [OPW-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPW-1:0] OP_REGIMM  = 6'h01;
  localparam logic [OPW-1:0] OP_J       = 6'h02;
  localparam logic [OPW-1:0] OP_JAL     = 6'h03;
  localparam logic [OPW-1:0] OP_BEQ     = 6'h04;
  localparam logic [OPW-1:0] OP_BNE     = 6'h05;
  localparam logic [OPW-1:0] OP_BLEZ    = 6'h06;
  localparam logic [OPW-1:0] OP_BGTZ    = 6'h07;
  localparam logic [FNW-1:0] FN_JR      = 6'h08;

  // address of the instruction a given number of bytes ahead
  function automatic word_t step_addr(word_t pc, int unsigned bytes);
    return pc + word_t'(bytes);
  endfunction

  // pc-relative target: following address plus word-scaled signed offset
  function automatic word_t rel_addr(word_t pc, logic [IMMW-1:0] off);
    word_t disp;
    disp = {{(XLEN-IMMW-2){off[IMMW-1]}}, off, 2'b00};
    return step_addr(pc, 4) + disp;
  endfunction

  // region-preserving absolute target
  function automatic word_t region_addr(word_t pc, logic [TGTW-1:0] tgt);
    word_t nxt;
    nxt = step_addr(pc, 4);
    return {nxt[XLEN-1 -: REGION_W], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output kind_e           kind_o
);
  logic [OPW-1:0]  op;
  logic [REGW-1:0] sub;
  logic [FNW-1:0]  fn;

  assign op  = instr_i[XLEN-1 -: OPW];
  assign sub = instr_i[XLEN-OPW-REGW-1 -: REGW];
  assign fn  = instr_i[FNW-1:0];

  always_comb begin
    kind_o = K_NONE;
    unique case (op)
      OP_SPECIAL: if (fn == FN_JR) kind_o = K_JR;
      OP_REGIMM: begin
        if (sub == REGW'(0))      kind_o = K_BLTZ;
        else if (sub == REGW'(1)) kind_o = K_BGEZ;
      end
      OP_J:    kind_o = K_J;
      OP_JAL:  kind_o = K_JAL;
      OP_BEQ:  kind_o = K_BEQ;
      OP_BNE:  kind_o = K_BNE;
      OP_BLEZ: if (sub == '0) kind_o = K_BLEZ;
      OP_BGTZ: if (sub == '0) kind_o = K_BGTZ;
      default: kind_o = K_NONE;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  kind_e           kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            ok_o
);
  logic same, neg, zero;

  assign same = (a_i == b_i);
  assign neg  = a_i[XLEN-1];
  assign zero = (a_i == '0);

  always_comb begin
    unique case (kind_i)
      K_BEQ:  ok_o = same;
      K_BNE:  ok_o = !same;
      K_BLTZ: ok_o = neg;
      K_BGEZ: ok_o = !neg;
      K_BLEZ: ok_o = neg || zero;
      K_BGTZ: ok_o = !neg && !zero;
      K_J, K_JAL, K_JR: ok_o = 1'b1;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] ret_o,
  output logic [XLEN-1:0] rel_o,
  output logic [XLEN-1:0] abs_o
);
  assign seq_o = step_addr(pc_i, 4);
  assign ret_o = step_addr(pc_i, 8);
  assign rel_o = rel_addr(pc_i, instr_i[IMMW-1:0]);
  assign abs_o = region_addr(pc_i, instr_i[TGTW-1:0]);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic        link_we_o,
  output logic [4:0]  link_addr_o,
  output logic [31:0] link_data_o
);
  kind_e     kind_w;
  logic      cond_w;
  word_t     seq_w, ret_w, rel_w, abs_w;
  word_t     nxt_w;
  logic      is_branch_w, is_jump_w, is_jr_w, take_w, link_w;

  npc_decode u_dec (.instr_i(instr_i), .kind_o(kind_w));

  npc_cond u_cond (.kind_i(kind_w), .a_i(rs_val_i), .b_i(rt_val_i), .ok_o(cond_w));

  npc_target u_tgt (
    .pc_i(pc_i), .instr_i(instr_i),
    .seq_o(seq_w), .ret_o(ret_w), .rel_o(rel_w), .abs_o(abs_w)
  );

  assign is_branch_w = (kind_w inside {K_BEQ, K_BNE, K_BLTZ, K_BGEZ, K_BLEZ, K_BGTZ});
  assign is_jump_w   = (kind_w inside {K_J, K_JAL});
  assign is_jr_w     = (kind_w == K_JR);
  assign take_w      = cond_w;
  assign link_w      = (kind_w == K_JAL);

  always_comb begin
    nxt_w = seq_w;
    if (take_w) begin
      if (is_branch_w)    nxt_w = rel_w;
      else if (is_jump_w) nxt_w = abs_w;
      else if (is_jr_w)   nxt_w = rs_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o   <= RESET_PC;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      next_pc_o   <= nxt_w;
      taken_o     <= take_w;
      link_we_o   <= link_w;
      link_data_o <= ret_w;
    end
  end

  assign link_addr_o = 5'(LINK_REG);

  AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !taken_o |-> next_pc_o == $past(pc_i) + 32'd4); // R10

  AST_LINK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && link_we_o |-> taken_o && link_addr_o == 5'd31 &&
      link_data_o == $past(pc_i) + 32'd8); // R9

  AST_REGIMM_BAD_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(instr_i[31:26]) == OP_REGIMM &&
      $past(instr_i[20:16]) > 5'd1 |-> !taken_o); // R5

  AST_JR_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_jr_w) |-> taken_o && next_pc_o == $past(rs_val_i)); // R8

  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_jump_w) |->
      next_pc_o[31:28] == $past(seq_w[31:28]) && next_pc_o[1:0] == 2'b00); // R7
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic [31:0] next_pc_o, link_data_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .link_we_o(link_we_o), .link_addr_o(link_addr_o),
    .link_data_o(link_data_o)
  );

  typedef struct packed {
    logic [31:0] pc, ins, a, b, nxt;
    logic        tk, lw;
    logic [31:0] ld;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{32'h00001000, 32'h10220003, 32'd5, 32'd5, 32'h00001010, 1'b1, 1'b0, 32'h0, "R3 "},
    '{32'h00001000, 32'h10220003, 32'd5, 32'd6, 32'h00001004, 1'b0, 1'b0, 32'h0, "R3 "},
    '{32'h00001000, 32'h1422FFFF, 32'd1, 32'd2, 32'h00001000, 1'b1, 1'b0, 32'h0, "R3 "},
    '{32'h00001000, 32'h1422FFFF, 32'd7, 32'd7, 32'h00001004, 1'b0, 1'b0, 32'h0, "R3 "},
    '{32'h00001000, 32'h04200010, 32'h80000000, 32'd0, 32'h00001044, 1'b1, 1'b0, 32'h0, "R11"},
    '{32'h00001000, 32'h04200010, 32'd0, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R4 "},
    '{32'h00001000, 32'h04210010, 32'd0, 32'd0, 32'h00001044, 1'b1, 1'b0, 32'h0, "R4 "},
    '{32'h00001000, 32'h04210010, 32'hFFFFFFFF, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R11"},
    '{32'h00001000, 32'h04230010, 32'h80000000, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R5 "},
    '{32'h00001000, 32'h18200010, 32'd0, 32'd0, 32'h00001044, 1'b1, 1'b0, 32'h0, "R6 "},
    '{32'h00001000, 32'h18200010, 32'd1, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R6 "},
    '{32'h00001000, 32'h1C200010, 32'h7FFFFFFF, 32'd0, 32'h00001044, 1'b1, 1'b0, 32'h0, "R11"},
    '{32'h00001000, 32'h1C200010, 32'h80000000, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R11"},
    '{32'h00001000, 32'h1C220010, 32'd5, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R6 "},
    '{32'h1FFFFFFC, 32'h0BFFFFFF, 32'd0, 32'd0, 32'h2FFFFFFC, 1'b1, 1'b0, 32'h0, "R7 "},
    '{32'h00001000, 32'h00600008, 32'hABCD1234, 32'd0, 32'hABCD1234, 1'b1, 1'b0, 32'h0, "R8 "},
    '{32'h00001000, 32'h00600020, 32'hABCD1234, 32'd0, 32'h00001004, 1'b0, 1'b0, 32'h0, "R8 "},
    '{32'h00400010, 32'h0C100000, 32'd0, 32'd0, 32'h00400000, 1'b1, 1'b1, 32'h00400018, "R9 "},
    '{32'h00001000, 32'h8C220004, 32'd3, 32'd3, 32'h00001004, 1'b0, 1'b0, 32'h0, "R10"},
    '{32'hFFFFFFFC, 32'h10220000, 32'd9, 32'd9, 32'h00000000, 1'b1, 1'b0, 32'h0, "R3 "}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b);
    pc_i = p; instr_i = i; rs_val_i = a; rt_val_i = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state while a jump-and-link is presented
    drive(32'h00400010, 32'h0C100000, 32'd0, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "next_pc", next_pc_o, 32'h0);
    chk("R1", "taken", {31'b0, taken_o}, 32'd0);
    chk("R1", "link_we", {31'b0, link_we_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k].pc, TBL[k].ins, TBL[k].a, TBL[k].b);
      @(posedge clk);
      #1;
      chk(string'(TBL[k].tag), "next_pc", next_pc_o, TBL[k].nxt);
      chk(string'(TBL[k].tag), "taken", {31'b0, taken_o}, {31'b0, TBL[k].tk});
      chk("R9", "link_we", {31'b0, link_we_o}, {31'b0, TBL[k].lw});
      if (TBL[k].lw) begin
        chk("R9", "link_data", link_data_o, TBL[k].ld);
        chk("R9", "link_addr", {27'b0, link_addr_o}, 32'd31);
      end
    end

    // R2: new inputs do not show before the next rising edge
    @(negedge clk);
    drive(32'h00001000, 32'h00600008, 32'hABCD1234, 32'd0);
    #1;
    chk("R2", "hold next_pc", next_pc_o, 32'h00000000);
    @(posedge clk);
    #1;
    chk("R2", "update next_pc", next_pc_o, 32'hABCD1234);
    chk("R8", "jr taken", {31'b0, taken_o}, 32'd1);

    // R1: asynchronous reset in mid-run drops the link request at once
    @(negedge clk);
    drive(32'h00400010, 32'h0C100000, 32'd0, 32'd0);
    @(posedge clk);
    #1;
    chk("R9", "link_we before reset", {31'b0, link_we_o}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "async link_we", {31'b0, link_we_o}, 32'd0);
    chk("R1", "async next_pc", next_pc_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule